// File: doc/BRIEF.md
# Instruction Fetch Miss Stall Controller

This block steers the fetch stage of a five-stage pipeline that reads its instructions from an instruction cache. Each running cycle it presents the program counter to the cache and advances the counter by one instruction word. At the next clock edge it captures three things: the returned word and its hit flag into the fetch/decode register, and the looked-up address into a memory address register (MAR). The cache arrays live outside the block. The controller sees only the hit flag and the read data.

A miss is found one cycle after the lookup, when the captured hit flag is low. In that cycle the controller raises stall and flush. The flush squashes the decode stage, so the register operands read for the bad word are never used. The controller also rewinds the program counter by one instruction word, back to the missing address. It then sends a single read request for the MAR address to memory and waits for the ready strobe, which may arrive any number of cycles (at least one) later. It hands the returned word to the cache for writing at the MAR address, where the cache takes the index and tag from the address. After one restart cycle, fetch resumes at the rewound address, and that lookup now hits.

Top module: `ifetch_miss_ctrl`

## Requirements
- R1: In a running cycle with no miss pending, `ic_addr_o` is the program counter. At the next edge the counter grows by DATA_W/8 (4), and the looked-up address is captured into the MAR.
- R2: A word whose lookup hit is shown on `fd_instr_o` with `fd_valid_o`=1 in the cycle after its lookup, with `stall_o`=0. Valid words come out in strictly ascending address order, with none missing and none repeated.
- R3: When the previous cycle was a running lookup that missed, the current cycle has `flush_o`=1 and `stall_o`=1. The lookup made during that cycle is discarded. In the following cycle, `ic_addr_o` equals the missing address, which is the counter minus 4.
- R4: While `flush_o` is 1, `fd_valid_o` is 0 and `stall_o` is 1, so decode drops the bad word and the operands read for it.
- R5: In the cycle after the flush, `mem_req_o` is high for exactly one cycle with `mem_addr_o` equal to the missing address. At no other time is `mem_req_o` high.
- R6: After the request, the block waits any number of cycles (at least one) for `mem_ready_i`. It captures `mem_rdata_i` in the cycle where `mem_ready_i` is 1.
- R7: In the cycle after the captured ready, `fill_en_o` is high for exactly one cycle, with `fill_addr_o` equal to the missing address and `fill_data_o` equal to the captured word.
- R8: After the fill cycle comes one restart cycle with `stall_o`=1. The next cycle is a running lookup with `stall_o`=0 at the missing address, and that lookup hits. `stall_o` stays 1 in every cycle from miss detection through restart, and the program counter does not move during that time.
- R9: During reset, `ic_addr_o` is RESET_PC (0), and `stall_o`, `flush_o`, `mem_req_o`, `fill_en_o` and `fd_valid_o` are all 0.
- R10: A `mem_ready_i` pulse while no read is outstanding is ignored: no fill follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ic_addr_o | output | ADDR_W | Lookup address given to the instruction cache |
| cache_hit_i | input | 1 | Cache hit flag for `ic_addr_o` |
| cache_rdata_i | input | DATA_W | Cache read word for `ic_addr_o` |
| fd_instr_o | output | DATA_W | Fetch/decode register contents |
| fd_valid_o | output | 1 | Decode may use `fd_instr_o` |
| stall_o | output | 1 | Hold the later pipeline stages |
| flush_o | output | 1 | Squash the word in decode |
| mem_req_o | output | 1 | One-cycle memory read request |
| mem_addr_o | output | ADDR_W | Read address (MAR) |
| mem_ready_i | input | 1 | Memory read completion strobe |
| mem_rdata_i | input | DATA_W | Memory read word, valid with `mem_ready_i` |
| fill_en_o | output | 1 | Cache write strobe |
| fill_addr_o | output | ADDR_W | Cache write address; the cache derives index and tag from it |
| fill_data_o | output | DATA_W | Cache write word |

## Verification
On every cycle, the assertions check that the rewind lands on the captured address and that the counter advances or holds as it should. They also check that request and fill are single-cycle pulses, that the fill carries the word captured with the ready strobe, that a stray ready produces no fill, and that the restart cycle is followed by an unstalled fetch. The end-to-end properties need the bench's scenarios: valid words arrive in order with none lost or repeated, every refetch after a refill hits, and the miss sequence holds up under memory latencies from 1 to 7 cycles. The bench exercises this against a cache model that it preloads and invalidates at random.

// File: rtl/fic_pkg.sv
package fic_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_MISS_REQ,
        ST_MISS_WAIT,
        ST_FILL,
        ST_RESTART
    } fic_state_e;
endpackage

// File: rtl/fic_fetch_path.sv
module fic_fetch_path #(
    parameter int          ADDR_W   = 32,
    parameter int          DATA_W   = 32,
    parameter int unsigned RESET_PC = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              cache_hit_i,
    input  logic [DATA_W-1:0] cache_rdata_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] mar_o,
    output logic [DATA_W-1:0] instr_o,
    output logic              valid_o,
    output logic              miss_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] instr;
        logic              hit;
        logic              full;
    } fetch_t;

    fetch_t q, d;
    logic   miss;

    assign miss = run_i && q.full && !q.hit;

    always_comb begin
        d = q;
        if (run_i) begin
            if (miss) begin
                d.pc   = q.pc - STEP;
                d.full = 1'b0;
            end else begin
                d.instr = cache_rdata_i;
                d.hit   = cache_hit_i;
                d.mar   = q.pc;
                d.full  = 1'b1;
                d.pc    = q.pc + STEP;
            end
        end else begin
            d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{pc: ADDR_W'(RESET_PC), default: '0};
        end else begin
            q <= d;
        end
    end

    assign pc_o    = q.pc;
    assign mar_o   = q.mar;
    assign instr_o = q.instr;
    assign valid_o = run_i && q.full && q.hit;
    assign miss_o  = miss;

    // R3
    rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> (q.pc == $past(q.mar)));

    // R1
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !miss) |=> (q.pc == $past(q.pc) + STEP && q.mar == $past(q.pc)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> ($stable(q.pc) && $stable(q.mar)));
endmodule

// File: rtl/fic_miss_fsm.sv
module fic_miss_fsm
    import fic_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_i,
    input  logic              mem_ready_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              run_o,
    output logic              mem_req_o,
    output logic              fill_en_o,
    output logic [DATA_W-1:0] fill_data_o
);
    typedef struct packed {
        fic_state_e        st;
        logic [DATA_W-1:0] line;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_RUN:       if (miss_i) d.st = ST_MISS_REQ;
            ST_MISS_REQ:  d.st = ST_MISS_WAIT;
            ST_MISS_WAIT: begin
                if (mem_ready_i) begin
                    d.line = mem_rdata_i;
                    d.st   = ST_FILL;
                end
            end
            ST_FILL:      d.st = ST_RESTART;
            ST_RESTART:   d.st = ST_RUN;
            default:      d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_RUN, default: '0};
        end else begin
            q <= d;
        end
    end

    assign run_o       = (q.st == ST_RUN);
    assign mem_req_o   = (q.st == ST_MISS_REQ);
    assign fill_en_o   = (q.st == ST_FILL);
    assign fill_data_o = q.line;

    // R5
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);

    // R6
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_MISS_WAIT && mem_ready_i) |=> (fill_en_o && fill_data_o == $past(mem_rdata_i)));

    // R7
    fill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en_o |=> !fill_en_o);

    // R10
    stray_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && mem_ready_i) |=> !fill_en_o);
endmodule

// File: rtl/ifetch_miss_ctrl.sv
module ifetch_miss_ctrl #(
    parameter int          ADDR_W   = 32,
    parameter int          DATA_W   = 32,
    parameter int unsigned RESET_PC = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] ic_addr_o,
    input  logic              cache_hit_i,
    input  logic [DATA_W-1:0] cache_rdata_i,
    output logic [DATA_W-1:0] fd_instr_o,
    output logic              fd_valid_o,
    output logic              stall_o,
    output logic              flush_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_ready_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              fill_en_o,
    output logic [ADDR_W-1:0] fill_addr_o,
    output logic [DATA_W-1:0] fill_data_o
);
    logic              run;
    logic              miss;
    logic [ADDR_W-1:0] mar;

    fic_fetch_path #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .RESET_PC(RESET_PC)
    ) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run),
        .cache_hit_i  (cache_hit_i),
        .cache_rdata_i(cache_rdata_i),
        .pc_o         (ic_addr_o),
        .mar_o        (mar),
        .instr_o      (fd_instr_o),
        .valid_o      (fd_valid_o),
        .miss_o       (miss)
    );

    fic_miss_fsm #(
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_i     (miss),
        .mem_ready_i(mem_ready_i),
        .mem_rdata_i(mem_rdata_i),
        .run_o      (run),
        .mem_req_o  (mem_req_o),
        .fill_en_o  (fill_en_o),
        .fill_data_o(fill_data_o)
    );

    assign stall_o     = !run || miss;
    assign flush_o     = miss;
    assign mem_addr_o  = mar;
    assign fill_addr_o = mar;

    // R4
    flush_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (stall_o && !fd_valid_o));

    // R2
    valid_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fd_valid_o |-> !stall_o);

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en_o |=> stall_o ##1 !stall_o);
endmodule

// File: tb/test_ifetch_miss_ctrl.sv
module test_ifetch_miss_ctrl;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ic_addr;
    logic          cache_hit;
    logic [DW-1:0] cache_rdata;
    logic [DW-1:0] fd_instr;
    logic          fd_valid, stall, flush, mem_req, fill_en;
    logic [AW-1:0] mem_addr, fill_addr;
    logic          mem_ready = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] fill_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    ifetch_miss_ctrl i_ifetch_miss_ctrl (
        .clk(clk), .rst_n(rst_n), .ic_addr_o(ic_addr),
        .cache_hit_i(cache_hit), .cache_rdata_i(cache_rdata),
        .fd_instr_o(fd_instr), .fd_valid_o(fd_valid), .stall_o(stall), .flush_o(flush),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
        .fill_en_o(fill_en), .fill_addr_o(fill_addr), .fill_data_o(fill_data)
    );

    function automatic logic [DW-1:0] prog(input logic [AW-1:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // cache model: 16 direct-mapped words, index addr[5:2], tag addr[31:6]
    logic          cval [16];
    logic [AW-7:0] ctag [16];
    logic [DW-1:0] cdat [16];
    logic          op_req = 1'b0;
    logic          op_load = 1'b0;
    logic [AW-1:0] op_addr = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) cval[i] <= 1'b0;
        end else begin
            if (fill_en) begin
                cval[fill_addr[5:2]] <= 1'b1;
                ctag[fill_addr[5:2]] <= fill_addr[AW-1:6];
                cdat[fill_addr[5:2]] <= fill_data;
            end
            if (op_req) begin
                cval[op_addr[5:2]] <= op_load;
                ctag[op_addr[5:2]] <= op_addr[AW-1:6];
                cdat[op_addr[5:2]] <= prog(op_addr);
            end
        end
    end

    always_comb begin
        cache_hit   = cval[ic_addr[5:2]] && (ctag[ic_addr[5:2]] == ic_addr[AW-1:6]);
        cache_rdata = cache_hit ? cdat[ic_addr[5:2]] : (32'hBAD0_0000 ^ ic_addr);
    end

    // memory responder
    int   lat_force = 1;
    logic spur = 1'b0;
    always begin
        int            lat;
        logic [AW-1:0] a;
        @(negedge clk);
        if (rst_n && mem_req) begin
            a   = mem_addr;
            lat = (lat_force > 0) ? lat_force : $urandom_range(1, 6);
            repeat (lat) @(posedge clk);
            #1;
            mem_ready = 1'b1;
            mem_rdata = prog(a);
            @(posedge clk);
            #1;
            mem_ready = 1'b0;
            mem_rdata = $urandom;
        end else if (rst_n && spur) begin
            @(posedge clk);
            #1;
            mem_ready = 1'b1;
            mem_rdata = $urandom;
            @(posedge clk);
            #1;
            mem_ready = 1'b0;
        end
    end

    // cycle monitor
    logic          p_ns, p_hit, p_flush, p_rw, waiting;
    logic [AW-1:0] p_addr, exp_pc;
    int            sf;
    int            nvalid;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_ns = 0; p_hit = 0; p_flush = 0; p_rw = 0; waiting = 0;
            p_addr = '0; exp_pc = '0; sf = 0; nvalid = 0;
        end else begin
            chk(fd_valid == (p_ns && p_hit), "R2 fd_valid timing", fd_valid, p_ns && p_hit);
            if (fd_valid) begin
                chk(fd_instr == prog(exp_pc), "R2 word order", fd_instr, prog(exp_pc));
                chk(!stall, "R2 valid without stall", stall, 0);
                exp_pc = exp_pc + 4;
                nvalid++;
            end
            chk(flush == (p_ns && !p_hit), "R3 flush on miss", flush, p_ns && !p_hit);
            if (flush) chk(stall && !fd_valid, "R4 squash", {stall, fd_valid}, 2'b10);
            if (p_ns) chk(ic_addr == p_addr + 4, "R1 advance", ic_addr, p_addr + 4);
            if (p_flush) chk(ic_addr == exp_pc, "R3 rewind", ic_addr, exp_pc);
            chk(mem_req == p_flush, "R5 request pulse", mem_req, p_flush);
            if (mem_req) chk(mem_addr == exp_pc, "R5 request addr", mem_addr, exp_pc);
            if (waiting) chk(stall, "R8 stall while waiting", stall, 1);
            chk(fill_en == p_rw, "R7/R10 fill timing", fill_en, p_rw);
            if (fill_en) begin
                chk(fill_addr == exp_pc, "R7 fill addr", fill_addr, exp_pc);
                chk(fill_data == prog(exp_pc), "R6 captured word", fill_data, prog(exp_pc));
            end
            if (sf == 1) chk(stall && ic_addr == exp_pc, "R8 restart cycle", ic_addr, exp_pc);
            if (sf == 2) chk(!stall && cache_hit && ic_addr == exp_pc, "R8 refetch hit",
                             {stall, cache_hit}, 2'b01);
            p_ns    = !stall;
            p_hit   = cache_hit;
            p_addr  = ic_addr;
            p_flush = flush;
            p_rw    = waiting && mem_ready;
            if (waiting && mem_ready) waiting = 0;
            if (mem_req) waiting = 1;
            if (fill_en) sf = 1;
            else if (sf == 1) sf = 2;
            else sf = 0;
        end
    end

    task automatic run_cycles(input int n, input bit with_ops, input int spur_every);
        for (int c = 0; c < n; c++) begin
            @(posedge clk);
            #2;
            op_req = 1'b0;
            spur   = 1'b0;
            if (!stall && with_ops) begin
                int r;
                r = $urandom_range(0, 7);
                if (r < 5) begin
                    op_req  = 1'b1;
                    op_load = 1'b1;
                    op_addr = ic_addr + 4 * $urandom_range(1, 4);
                end else if (r == 5) begin
                    op_req  = 1'b1;
                    op_load = 1'b0;
                    op_addr = ic_addr + 4 * $urandom_range(1, 15);
                end
            end
            if (!stall && spur_every > 0 && (c % spur_every) == 0) spur = 1'b1;
        end
        @(posedge clk);
        #2;
        op_req = 1'b0;
        spur   = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk(ic_addr == 0, "R9 reset pc", ic_addr, 0);
        chk(!stall && !flush, "R9 reset stall/flush", {stall, flush}, 0);
        chk(!mem_req && !fill_en, "R9 reset req/fill", {mem_req, fill_en}, 0);
        chk(!fd_valid, "R9 reset valid", fd_valid, 0);
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        // directed: empty cache, every fetch misses, shortest latency
        lat_force = 1;
        run_cycles(60, 1'b0, 0);
        // directed: long latency
        lat_force = 7;
        run_cycles(60, 1'b0, 0);
        // random mix with preloads, invalidations and stray ready pulses (R10)
        lat_force = 0;
        run_cycles(4000, 1'b1, 97);
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(nvalid > 200, "R2 forward progress", nvalid, 200);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule